// File: doc/BRIEF.md
# Interleaved Column Lifting Filter

This block applies a two-step lifting transform down the columns of an image that arrives two rows at a time. In every accepted cycle it takes one column's even-row sample and odd-row sample together. The columns of an image row pair follow one another, so one pass over all N columns completes a scan. Nothing from a column survives in registers until that column comes back. Instead, each column leaves two partial sums in a pair of line memories, and it picks them up again one scan later.

Each memory holds 2N words and is split into two halves. During a scan the block reads the previous scan's partial sums from one half while writing the current scan's partial sums into the other half. The memory address follows the column counter. The first scan only primes the memories. The second scan mirrors the top edge of the image. From the third scan on, the block runs the regular recurrence and emits one low-pass/high-pass pair per accepted input.

The multipliers are separated by pipeline registers, so no path between registers holds more than one multiplier.

Top module: `col_lift_filter`

## Requirements
- R1: While reset is high, and right after it, `out_valid`, `out_low`, `out_high` and `out_col` are all zero.
- R2: An input accepted at a rising edge (`in_valid` high) that produces an output shows it, with `out_valid` high, after the third rising edge that follows.
- R3: The first N accepted inputs after reset (scan 0) produce no output; `out_valid` stays low for them.
- R4: Let q(c,v) = floor(c·v/256), where c is a signed coefficient in units of 1/256. For a column whose samples are (e_k, o_k) in scan k, scan k ≥ 1 emits h = o_{k-1} + q(A,e_{k-1}) + q(A,e_k) on `out_high`.
- R5: For scan k ≥ 2, `out_low` = e_{k-1} + q(B,h_{k-2}) + q(B,h_{k-1}), where h_j is the high value defined in R4.
- R6: For scan 1 (the top edge), `out_low` = e_0 + 2·q(B,h_0), so the missing high value above the image is mirrored.
- R7: Accepted inputs are assigned to columns 0,1,…,N−1 in order, wrapping to the next scan. `out_col` reports the column of the pair being emitted.
- R8: A cycle with `in_valid` low advances no counter and changes no stored value. The cycle that would have carried its output shows `out_valid` low, and `out_low` and `out_high` keep their values.
- R9: Each column's results depend only on that column's own samples, even though columns are interleaved.
- R10: In the same cycle, a line memory never reads and writes the same word. Reads use the half of scan k−1, and writes use the half of scan k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new image |
| in_valid | input | 1 | Sample pair present this cycle |
| in_even | input | DATA_W (10) | Even-row sample, signed |
| in_odd | input | DATA_W (10) | Odd-row sample, signed |
| out_valid | output | 1 | Output pair present |
| out_low | output | ACC_W (14) | Low-pass result, signed |
| out_high | output | ACC_W (14) | High-pass result, signed |
| out_col | output | clog2(N) | Column of the emitted pair |

## Verification
The bench runs a small image through the filter and computes each column's expected history arithmetically. It checks the first two scans separately: a design that emitted during scan 0, or that skipped the top-edge mirroring, would produce a wrong first low-pass row. Idle cycles are inserted between inputs. A design that advanced its counters or wrote memory on an idle cycle would shift results into the wrong column or scan. Each column gets different data, and samples at full-scale magnitudes are run as well. A swapped memory half, a wrong address, or a truncated intermediate would show up as wrong values at that column.

// File: rtl/col_lift_pkg.sv
package col_lift_pkg;
    localparam int DATA_W = 10;
    localparam int ACC_W  = 14;
    localparam int COEF_W = 12;
    localparam int FRAC   = 8;

    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_STEADY = 2'd2
    } phase_e;

    typedef struct packed {
        logic   v;
        phase_e ph;
        acc_t   e;
        acc_t   o;
        acc_t   ae;
    } st1_t;

    typedef struct packed {
        logic   v;
        phase_e ph;
        acc_t   e;
        acc_t   h;
        acc_t   d1;
        acc_t   p2;
    } st2_t;

    typedef struct packed {
        logic   v;
        phase_e ph;
        acc_t   e;
        acc_t   h;
        acc_t   d1;
        acc_t   p2;
        acc_t   bh;
    } st3_t;

    function automatic acc_t qmul(input coef_t c, input acc_t v);
        logic signed [ACC_W+COEF_W-1:0] p;
        logic signed [ACC_W+COEF_W-1:0] s;
        p = (ACC_W+COEF_W)'(v) * (ACC_W+COEF_W)'(c);
        s = p >>> FRAC;
        return s[ACC_W-1:0];
    endfunction
endpackage

// File: rtl/col_lift_mem.sv
module col_lift_mem #(
    parameter int DEPTH = 32,
    parameter int W     = 14,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= store[rd_addr];
    end

    AST_PORTS_APART: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |-> (wr_addr != rd_addr)); // R10
endmodule

// File: rtl/col_lift_ctrl.sv
module col_lift_ctrl
    import col_lift_pkg::*;
#(
    parameter int N   = 16,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] col,
    output logic          bank,
    output phase_e        phase
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            col   <= '0;
            bank  <= 1'b0;
            phase <= PH_FIRST;
        end else if (adv) begin
            if (col == LAST) begin
                col  <= '0;
                bank <= ~bank;
                unique case (phase)
                    PH_FIRST:  phase <= PH_SECOND;
                    PH_SECOND: phase <= PH_STEADY;
                    default:   phase <= PH_STEADY;
                endcase
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        col <= LAST); // R7
    AST_PHASE_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STEADY) |=> (phase == PH_STEADY)); // R7
endmodule

// File: rtl/col_lift_filter.sv
module col_lift_filter
    import col_lift_pkg::*;
#(
    parameter int N       = 16,
    parameter int COEF_A  = -406,
    parameter int COEF_B  = -14,
    localparam int CW     = (N > 1) ? $clog2(N) : 1,
    localparam int DEPTH  = 2 * N,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_even,
    input  logic signed [DATA_W-1:0] in_odd,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_low,
    output logic signed [ACC_W-1:0]  out_high,
    output logic [CW-1:0]            out_col
);
    localparam coef_t CA = coef_t'(COEF_A);
    localparam coef_t CB = coef_t'(COEF_B);

    initial begin
        if (N < 4) $error("col_lift_filter needs N >= 4");
    end

    logic [CW-1:0] cur_col;
    logic          cur_bank;
    phase_e        cur_phase;

    col_lift_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .col   (cur_col),
        .bank  (cur_bank),
        .phase (cur_phase)
    );

    function automatic logic [AW-1:0] word_addr(input logic b, input logic [CW-1:0] c);
        return b ? AW'(N) + AW'(c) : AW'(c);
    endfunction

    // pipeline sidebands
    logic [AW-1:0] waddr1, waddr2, waddr3;
    logic [CW-1:0] col1, col2, col3;
    st1_t s1;
    st2_t s2;
    st3_t s3;

    // memory ports: index 0 carries the odd-side sum, 1 the even-side sum
    logic [ACC_W-1:0] mem_wdata [2];
    logic [ACC_W-1:0] mem_rdata [2];
    logic             mem_wen;
    logic [AW-1:0]    rd_addr0;

    assign rd_addr0 = word_addr(~cur_bank, cur_col);

    // stage 1: first multiplier, read issued
    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= '0;
            waddr1 <= '0;
            col1   <= '0;
        end else begin
            s1.v   <= in_valid;
            waddr1 <= word_addr(cur_bank, cur_col);
            col1   <= cur_col;
            if (in_valid) begin
                s1.ph <= cur_phase;
                s1.e  <= acc_t'(in_even);
                s1.o  <= acc_t'(in_odd);
                s1.ae <= qmul(CA, acc_t'(in_even));
            end
        end
    end

    // stage 2: high value and new odd-side sum
    always_ff @(posedge clk) begin
        if (rst) begin
            s2     <= '0;
            waddr2 <= '0;
            col2   <= '0;
        end else begin
            s2.v   <= s1.v;
            waddr2 <= waddr1;
            col2   <= col1;
            if (s1.v) begin
                s2.ph <= s1.ph;
                s2.e  <= s1.e;
                s2.d1 <= s1.o + s1.ae;
                s2.h  <= acc_t'(mem_rdata[0]) + s1.ae;
                s2.p2 <= acc_t'(mem_rdata[1]);
            end
        end
    end

    // stage 3: second multiplier
    always_ff @(posedge clk) begin
        if (rst) begin
            s3     <= '0;
            waddr3 <= '0;
            col3   <= '0;
        end else begin
            s3.v   <= s2.v;
            waddr3 <= waddr2;
            col3   <= col2;
            if (s2.v) begin
                s3.ph <= s2.ph;
                s3.e  <= s2.e;
                s3.h  <= s2.h;
                s3.d1 <= s2.d1;
                s3.p2 <= s2.p2;
                s3.bh <= qmul(CB, s2.h);
            end
        end
    end

    // write-back of both partial sums
    acc_t d2_new;
    acc_t low_new;
    always_comb begin
        d2_new  = (s3.ph == PH_FIRST) ? s3.e : s3.e + s3.bh;
        low_new = (s3.ph == PH_SECOND) ? s3.p2 + s3.bh + s3.bh : s3.p2 + s3.bh;
    end

    assign mem_wen      = s3.v;
    assign mem_wdata[0] = s3.d1;
    assign mem_wdata[1] = d2_new;

    for (genvar g = 0; g < 2; g++) begin : g_line
        col_lift_mem #(.DEPTH(DEPTH), .W(ACC_W)) u_mem (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (mem_wen),
            .wr_addr (waddr3),
            .wr_data (mem_wdata[g]),
            .rd_en   (in_valid),
            .rd_addr (rd_addr0),
            .rd_data (mem_rdata[g])
        );
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_low   <= '0;
            out_high  <= '0;
            out_col   <= '0;
        end else begin
            out_valid <= s3.v && (s3.ph != PH_FIRST);
            if (s3.v && (s3.ph != PH_FIRST)) begin
                out_low  <= low_new;
                out_high <= s3.h;
                out_col  <= col3;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 4)); // R2
    AST_FIRST_SCAN_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(cur_phase, 4) != PH_FIRST)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid, 4) |-> ($stable(out_low) && $stable(out_high) && !out_valid)); // R8
endmodule

// File: tb/col_lift_filter_tb.sv
`timescale 1ns/1ps
module col_lift_filter_tb;
    import col_lift_pkg::*;

    localparam int N  = 6;
    localparam int CA = -406;
    localparam int CB = -14;
    localparam int CW = $clog2(N);
    localparam int MAXC = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_even = '0;
    logic signed [DATA_W-1:0] in_odd = '0;
    logic out_valid;
    logic signed [ACC_W-1:0] out_low, out_high;
    logic [CW-1:0] out_col;

    always #4 clk = ~clk;

    col_lift_filter #(.N(N), .COEF_A(CA), .COEF_B(CB)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
        .out_valid(out_valid), .out_low(out_low), .out_high(out_high), .out_col(out_col)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    bit exp_v [MAXC];
    int exp_l [MAXC];
    int exp_h [MAXC];
    int exp_c [MAXC];
    int last_l = 0;
    int last_h = 0;

    int m_e [N];
    int m_o [N];
    int m_h [N];
    int m_col = 0;
    int m_scan = 0;

    function automatic int q(input int c, input int v);
        return (c * v) >>> FRAC;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic check_out();
        int i;
        if (cyc < 4) return;
        i = cyc - 4;
        if (exp_v[i]) begin
            chk(out_valid == 1'b1, "R2 out_valid", int'(out_valid), 1);
            chk(int'(out_high) == exp_h[i], "R4/R9 out_high", int'(out_high), exp_h[i]);
            chk(int'(out_low) == exp_l[i], "R5/R6/R10 out_low", int'(out_low), exp_l[i]);
            chk(int'(out_col) == exp_c[i], "R7 out_col", int'(out_col), exp_c[i]);
            last_l = exp_l[i];
            last_h = exp_h[i];
        end else begin
            chk(out_valid == 1'b0, "R3/R8 out_valid low", int'(out_valid), 0);
            chk(int'(out_low) == last_l, "R8 out_low held", int'(out_low), last_l);
            chk(int'(out_high) == last_h, "R8 out_high held", int'(out_high), last_h);
        end
    endtask

    task automatic step(input bit v, input int e, input int o);
        int h;
        int l;
        @(negedge clk);
        check_out();
        in_valid = v;
        in_even  = DATA_W'(e);
        in_odd   = DATA_W'(o);
        exp_v[cyc] = 1'b0;
        if (v) begin
            if (m_scan >= 1) begin
                h = m_o[m_col] + q(CA, m_e[m_col]) + q(CA, e);
                if (m_scan == 1) l = m_e[m_col] + 2 * q(CB, h);       // R6
                else             l = m_e[m_col] + q(CB, m_h[m_col]) + q(CB, h); // R5
                exp_v[cyc] = 1'b1;
                exp_h[cyc] = h;
                exp_l[cyc] = l;
                exp_c[cyc] = m_col;
                m_h[m_col] = h;
            end
            m_e[m_col] = e;
            m_o[m_col] = o;
            if (m_col == N - 1) begin
                m_col = 0;
                m_scan++;
            end else begin
                m_col++;
            end
        end
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: outputs cleared under reset
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(out_low == '0, "R1 out_low", int'(out_low), 0);
        chk(out_high == '0, "R1 out_high", int'(out_high), 0);
        chk(out_col == '0, "R1 out_col", int'(out_col), 0);
        rst = 1'b0;
        cyc = 0;
        last_l = 0;
        last_h = 0;
        m_col = 0;
        m_scan = 0;
        for (int i = 0; i < MAXC; i++) exp_v[i] = 1'b0;
    endtask

    task automatic flush();
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0);
    endtask

    initial begin
        int seed = 7;
        int e, o;
        // pass 1: back-to-back, per-column distinct data (R3..R7, R9, R10)
        do_reset();
        for (int s = 0; s < 6; s++)
            for (int c = 0; c < N; c++) begin
                e = ($urandom(seed + s * 31 + c) % 1024) - 512;
                o = ((s * 97 + c * 53 + 11) % 1024) - 512;
                step(1'b1, e, o);
            end
        flush();
        // pass 2: idle cycles interleaved (R8)
        do_reset();
        for (int s = 0; s < 5; s++)
            for (int c = 0; c < N; c++) begin
                e = ((s * 211 + c * 37) % 1024) - 512;
                o = ((s * 19 + c * 151 + 3) % 1024) - 512;
                step(1'b1, e, o);
                if (((s * N + c) % 3) == 1) step(1'b0, 99, -99);
                if (((s * N + c) % 7) == 4) begin
                    step(1'b0, -7, 7);
                    step(1'b0, 300, 1);
                end
            end
        flush();
        // pass 3: full-scale corners
        do_reset();
        for (int s = 0; s < 5; s++)
            for (int c = 0; c < N; c++) begin
                e = ((s + c) % 2 == 0) ? 511 : -512;
                o = ((s + 2 * c) % 3 == 0) ? -512 : 511;
                step(1'b1, e, o);
            end
        flush();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule